// File: doc/BRIEF.md
# Transaction Commit Packet Broadcaster

This block sits between a processor node's store path and a shared broadcast bus. While a transaction runs, every store lands in a small buffer indexed by cache line. The buffer keeps the line address, the line data and a per-byte dirty mask. A store to a line that is already buffered merges into that entry. Stores tagged as local take an entry, so they still count against capacity, but they never leave the node.

When the transaction has finished and the node holds permission to commit, the commit input starts the send. The block then streams all buffered lines back-to-back as one uninterrupted packet, and nothing from another commit can fall inside it. Each line is sent as a record with a 4-byte address header. In update mode, 64 bytes of line data follow the header, with a byte strobe that is set only on dirty bytes. In invalidate mode only the header is sent.

A violation abort empties the buffer in one cycle and sends nothing. A one-cycle done pulse marks the end of every commit. From that same cycle the buffer is empty and accepts stores for the next transaction.

Top module: `txn_commit_bcast`

## Requirements
- R1: While no commit is in progress, bus_valid stays low and bus_data and bus_be are zero. Buffered stores appear on the bus only after cmt_go.
- R2: A store to a line already held merges into that entry and takes no new one. Its enabled bytes replace the old data and are ORed into the dirty mask. Bytes written earlier and not overwritten keep their earlier values.
- R3: A store to a new line when all N_ENT entries are in use raises st_ovf and drops st_ready, and the store is not taken. A store to a line already held is still accepted while the buffer is full.
- R4: A local store (st_local=1) allocates an entry for a new line but marks no byte dirty. A line that only local stores have touched is left out of the packet. Local bytes never reach the bus.
- R5: A line record starts with header record bytes 0..3, which carry the line byte address (st_laddr times 64) in little-endian order. In update mode, line byte i follows as record byte 4+i. Record byte j goes out on beat j/BUS_B, lane j%BUS_B, at bus_data bits [8*lane+7:8*lane].
- R6: A line takes ceil(68/BUS_B) beats in update mode and ceil(4/BUS_B) beats in invalidate mode. bus_be is 1 on header lanes and 1 on data lanes only where the byte is dirty. Clean data bytes and lanes past the record end carry zero data and a zero strobe.
- R7: Lines go out in the order their first store arrived in the transaction. All beats of one commit are on consecutive cycles with no gap. bus_sop marks the first beat of the packet and bus_eop marks the last.
- R8: cmt_upd is sampled together with cmt_go: 1 selects update mode and 0 selects invalidate mode for the whole packet.
- R9: txn_abort while idle clears every entry in one cycle and sends nothing. When txn_abort and cmt_go are high in the same cycle, the abort wins. txn_abort has no effect while a packet is being sent.
- R10: cmt_done pulses for exactly one cycle right after the last beat, or in the cycle after cmt_go when no line has dirty bytes. In that cycle bus_valid is low, the buffer is empty and st_ready is high.
- R11: A store presented while a packet is being sent, or in a cycle where cmt_go or txn_abort is high, sees st_ready low and leaves no trace in any later packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_laddr | input | 26 | Line address of the store (byte address / 64) |
| st_word | input | 3 | 8-byte word index within the line |
| st_be | input | 8 | Byte enables within the word |
| st_data | input | 64 | Store data, byte b on bits [8b+7:8b] |
| st_local | input | 1 | Store is node-local and never broadcast |
| st_ready | output | 1 | Store would be accepted this cycle |
| st_ovf | output | 1 | Store needs a new entry and none is free |
| cmt_go | input | 1 | Commit permission held; start sending |
| cmt_upd | input | 1 | 1 = update packet, 0 = invalidate packet |
| txn_abort | input | 1 | Violation abort; discard the transaction |
| bus_valid | output | 1 | A beat is on the bus |
| bus_data | output | 64 | Beat data |
| bus_be | output | 8 | Per-lane byte strobe |
| bus_sop | output | 1 | First beat of the packet |
| bus_eop | output | 1 | Last beat of the packet |
| cmt_done | output | 1 | One-cycle pulse when the commit has finished |

## Verification
The hardest state to reach is a full buffer whose contents mix merged lines, a local-only line and partially dirty bytes, followed by a send that is disturbed by a stray store and an abort partway through. A table of stores fills every entry through a merge and a local allocation, so the next new line overflows. A later store then hits a held line while the buffer is full. The update commit that follows injects a store and an abort in the middle of its beat stream. The beat stream is checked against a byte-level model built from those stores. Separate runs cover invalidate packets, abort before commit, abort together with commit, and an empty commit.

// File: rtl/txcb_pkg.sv
package txcb_pkg;

  typedef enum logic {
    SND_IDLE = 1'b0,
    SND_RUN  = 1'b1
  } snd_st_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/txcb_line_buf.sv
module txcb_line_buf #(
  parameter int N_ENT   = 4,
  parameter int LADDR_W = 26,
  parameter int LINE_B  = 64,
  parameter int ST_B    = 8,
  parameter int IDX_W   = 2,
  parameter int WORD_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [LADDR_W-1:0]    st_laddr,
  input  logic [WORD_W-1:0]     st_word,
  input  logic [ST_B-1:0]       st_be,
  input  logic [ST_B*8-1:0]     st_data,
  input  logic                  st_local,
  input  logic                  clr,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic                  hit_o,
  output logic                  free_o,
  output logic [LADDR_W-1:0]    rd_laddr,
  output logic [LINE_B*8-1:0]   rd_data,
  output logic [LINE_B-1:0]     rd_mask,
  output logic [N_ENT-1:0]      bc_vec
);

  logic [N_ENT-1:0]    valid_q, valid_d;
  logic [LINE_B-1:0]   mask_q [N_ENT];
  logic [LINE_B-1:0]   mask_d [N_ENT];
  logic [LADDR_W-1:0]  laddr_q [N_ENT];
  logic [LINE_B*8-1:0] data_q [N_ENT];

  logic [N_ENT-1:0]    hit_vec;
  logic                hit_any, free_any, we;
  logic [IDX_W-1:0]    hit_idx, alloc_idx, tgt;
  logic [LINE_B-1:0]   lane_sel;
  logic [LINE_B*8-1:0] lane_dat;

  // line match and lowest free slot
  always_comb begin
    hit_idx   = '0;
    alloc_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      hit_vec[i] = valid_q[i] && (laddr_q[i] == st_laddr);
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (!valid_q[i]) alloc_idx = IDX_W'(i);
    end
  end

  assign hit_any  = |hit_vec;
  assign free_any = ~&valid_q;
  assign tgt      = hit_any ? hit_idx : alloc_idx;
  assign we       = wr_en && (hit_any || free_any) && !clr;
  assign hit_o    = hit_any;
  assign free_o   = free_any;

  // spread the store word over the line byte lanes
  always_comb begin
    for (int b = 0; b < LINE_B; b++) begin
      lane_sel[b] = (WORD_W'(b / ST_B) == st_word) && st_be[b % ST_B] && !st_local;
      lane_dat[b*8 +: 8] = st_data[(b % ST_B)*8 +: 8];
    end
  end

  // next state for valid and dirty mask
  always_comb begin
    valid_d = valid_q;
    for (int i = 0; i < N_ENT; i++) mask_d[i] = mask_q[i];
    if (clr) begin
      valid_d = '0;
      for (int i = 0; i < N_ENT; i++) mask_d[i] = '0;
    end else if (we) begin
      valid_d[tgt] = 1'b1;
      mask_d[tgt]  = (hit_any ? mask_q[tgt] : '0) | lane_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < N_ENT; i++) mask_q[i] <= '0;
    end else begin
      valid_q <= valid_d;
      for (int i = 0; i < N_ENT; i++) mask_q[i] <= mask_d[i];
    end
  end

  // payload storage, write-enabled, no reset
  always_ff @(posedge clk) begin
    if (we) begin
      if (!hit_any) laddr_q[tgt] <= st_laddr;
      for (int b = 0; b < LINE_B; b++) begin
        if (lane_sel[b]) data_q[tgt][b*8 +: 8] <= lane_dat[b*8 +: 8];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_ENT; i++) bc_vec[i] = valid_q[i] && (|mask_q[i]);
  end

  assign rd_laddr = laddr_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
  assign rd_mask  = mask_q[rd_idx];

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_any && !free_any && !clr) |=> $stable(valid_q));

  // R9
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_q == '0));

  // R2
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/txcb_beat_fmt.sv
module txcb_beat_fmt #(
  parameter int LADDR_W   = 26,
  parameter int LINE_B    = 64,
  parameter int HDR_B     = 4,
  parameter int BUS_B     = 8,
  parameter int UPD_BEATS = 9,
  parameter int BEAT_W    = 4
) (
  input  logic [LADDR_W-1:0]  laddr,
  input  logic [LINE_B*8-1:0] data,
  input  logic [LINE_B-1:0]   mask,
  input  logic                upd,
  input  logic [BEAT_W-1:0]   beat,
  output logic [BUS_B*8-1:0]  bdata,
  output logic [BUS_B-1:0]    bbe
);

  localparam int REC_B = HDR_B + LINE_B;
  localparam int PAD_B = UPD_BEATS * BUS_B;
  localparam int OFS_W = $clog2(LINE_B);

  logic [HDR_B*8-1:0] hdr;
  logic [7:0]         rb  [PAD_B];
  logic               rs  [PAD_B];

  assign hdr = {laddr, {OFS_W{1'b0}}};

  // record image: header, then dirty data bytes in update mode, then padding
  always_comb begin
    for (int j = 0; j < PAD_B; j++) begin
      rb[j] = 8'h00;
      rs[j] = 1'b0;
      if (j < HDR_B) begin
        rb[j] = hdr[(j % HDR_B)*8 +: 8];
        rs[j] = 1'b1;
      end else if (j < REC_B) begin
        rs[j] = upd && mask[(j - HDR_B) % LINE_B];
        rb[j] = rs[j] ? data[((j - HDR_B) % LINE_B)*8 +: 8] : 8'h00;
      end
    end
  end

  for (genvar l = 0; l < BUS_B; l++) begin : g_lane
    always_comb begin
      int idx;
      idx = int'(beat) * BUS_B + l;
      if (idx < PAD_B) begin
        bdata[l*8 +: 8] = rb[idx];
        bbe[l]          = rs[idx];
      end else begin
        bdata[l*8 +: 8] = 8'h00;
        bbe[l]          = 1'b0;
      end
    end
  end

endmodule

// File: rtl/txcb_send_ctl.sv
module txcb_send_ctl
  import txcb_pkg::*;
#(
  parameter int N_ENT     = 4,
  parameter int IDX_W     = 2,
  parameter int BEAT_W    = 4,
  parameter int UPD_BEATS = 9,
  parameter int INV_BEATS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              abort,
  input  logic              upd_in,
  input  logic [N_ENT-1:0]  bc_vec,
  output logic              busy,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [BEAT_W-1:0] beat,
  output logic              mode,
  output logic              bvalid,
  output logic              sop,
  output logic              eop,
  output logic              done,
  output logic              clr
);

  snd_st_e           st_q, st_d;
  logic [N_ENT-1:0]  pend_q, pend_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              mode_q, mode_d;
  logic              first_q, first_d;
  logic              done_q, done_d;
  logic              last_beat, last_line, run;

  // oldest pending line first
  always_comb begin
    cur_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (pend_q[i]) cur_idx = IDX_W'(i);
    end
  end

  assign run       = (st_q == SND_RUN);
  assign last_beat = mode_q ? (beat_q == BEAT_W'(UPD_BEATS - 1))
                            : (beat_q == BEAT_W'(INV_BEATS - 1));
  assign last_line = ((pend_q & ~(N_ENT'(1) << cur_idx)) == '0);

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    beat_d  = beat_q;
    mode_d  = mode_q;
    first_d = first_q;
    done_d  = 1'b0;
    clr     = 1'b0;
    case (st_q)
      SND_IDLE: begin
        if (abort) begin
          clr = 1'b1;
        end else if (go) begin
          mode_d = upd_in;
          beat_d = '0;
          if (bc_vec == '0) begin
            clr    = 1'b1;
            done_d = 1'b1;
          end else begin
            st_d    = SND_RUN;
            pend_d  = bc_vec;
            first_d = 1'b1;
          end
        end
      end
      default: begin
        beat_d = beat_q + 1'b1;
        if (last_beat) begin
          beat_d          = '0;
          first_d         = 1'b0;
          pend_d[cur_idx] = 1'b0;
          if (last_line) begin
            st_d   = SND_IDLE;
            done_d = 1'b1;
            clr    = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SND_IDLE;
      pend_q  <= '0;
      beat_q  <= '0;
      mode_q  <= 1'b0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      beat_q  <= beat_d;
      mode_q  <= mode_d;
      first_q <= first_d;
      done_q  <= done_d;
    end
  end

  assign busy   = run;
  assign beat   = beat_q;
  assign mode   = mode_q;
  assign bvalid = run;
  assign sop    = run && first_q && (beat_q == '0);
  assign eop    = run && last_beat && last_line;
  assign done   = done_q;

  // R7
  burst_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !eop) |=> bvalid);

  // R10
  done_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> (done && !bvalid));

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && abort) |=> (!bvalid && !done));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/txn_commit_bcast.sv
module txn_commit_bcast
  import txcb_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int BUS_B  = 8,
  parameter int LINE_B = 64,
  parameter int HDR_B  = 4,
  parameter int ST_B   = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  st_valid,
  input  logic [HDR_B*8-$clog2(LINE_B)-1:0]     st_laddr,
  input  logic [$clog2(LINE_B/ST_B)-1:0]        st_word,
  input  logic [ST_B-1:0]                       st_be,
  input  logic [ST_B*8-1:0]                     st_data,
  input  logic                                  st_local,
  output logic                                  st_ready,
  output logic                                  st_ovf,
  input  logic                                  cmt_go,
  input  logic                                  cmt_upd,
  input  logic                                  txn_abort,
  output logic                                  bus_valid,
  output logic [BUS_B*8-1:0]                    bus_data,
  output logic [BUS_B-1:0]                      bus_be,
  output logic                                  bus_sop,
  output logic                                  bus_eop,
  output logic                                  cmt_done
);

  localparam int LADDR_W   = HDR_B * 8 - $clog2(LINE_B);
  localparam int WORD_W    = $clog2(LINE_B / ST_B);
  localparam int IDX_W     = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int UPD_BEATS = ceil_div(HDR_B + LINE_B, BUS_B);
  localparam int INV_BEATS = ceil_div(HDR_B, BUS_B);
  localparam int BEAT_W    = $clog2(UPD_BEATS + 1);

  logic                hit, free, busy, clr, open, accept;
  logic [N_ENT-1:0]    bc_vec;
  logic [IDX_W-1:0]    cur_idx;
  logic [BEAT_W-1:0]   beat;
  logic                mode, bvalid, sop, eop, done;
  logic [LADDR_W-1:0]  rd_laddr;
  logic [LINE_B*8-1:0] rd_data;
  logic [LINE_B-1:0]   rd_mask;
  logic [BUS_B*8-1:0]  f_data;
  logic [BUS_B-1:0]    f_be;

  assign open     = !busy && !cmt_go && !txn_abort;
  assign st_ready = open && (hit || free);
  assign st_ovf   = st_valid && open && !hit && !free;
  assign accept   = st_valid && st_ready;

  txcb_line_buf #(
    .N_ENT(N_ENT), .LADDR_W(LADDR_W), .LINE_B(LINE_B), .ST_B(ST_B),
    .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(accept),
    .st_laddr(st_laddr), .st_word(st_word), .st_be(st_be),
    .st_data(st_data), .st_local(st_local), .clr(clr),
    .rd_idx(cur_idx), .hit_o(hit), .free_o(free),
    .rd_laddr(rd_laddr), .rd_data(rd_data), .rd_mask(rd_mask),
    .bc_vec(bc_vec)
  );

  txcb_send_ctl #(
    .N_ENT(N_ENT), .IDX_W(IDX_W), .BEAT_W(BEAT_W),
    .UPD_BEATS(UPD_BEATS), .INV_BEATS(INV_BEATS)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .go(cmt_go), .abort(txn_abort),
    .upd_in(cmt_upd), .bc_vec(bc_vec), .busy(busy), .cur_idx(cur_idx),
    .beat(beat), .mode(mode), .bvalid(bvalid), .sop(sop), .eop(eop),
    .done(done), .clr(clr)
  );

  txcb_beat_fmt #(
    .LADDR_W(LADDR_W), .LINE_B(LINE_B), .HDR_B(HDR_B), .BUS_B(BUS_B),
    .UPD_BEATS(UPD_BEATS), .BEAT_W(BEAT_W)
  ) u_fmt (
    .laddr(rd_laddr), .data(rd_data), .mask(rd_mask), .upd(mode),
    .beat(beat), .bdata(f_data), .bbe(f_be)
  );

  assign bus_valid = bvalid;
  assign bus_data  = bvalid ? f_data : '0;
  assign bus_be    = bvalid ? f_be : '0;
  assign bus_sop   = sop;
  assign bus_eop   = eop;
  assign cmt_done  = done;

  // R11
  no_store_in_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !st_ready);

  // R1
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (bus_be == '0 && !bus_sop && !bus_eop));

endmodule

// File: tb/txn_commit_bcast_bench.sv
module txn_commit_bcast_bench;

  localparam int N   = 4;
  localparam int BB  = 8;
  localparam int LB  = 64;
  localparam int HB  = 4;
  localparam int SB  = 8;
  localparam int LAW = 26;
  localparam int UB  = 9;
  localparam int IB  = 1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           st_valid, st_local, st_ready, st_ovf;
  logic [LAW-1:0] st_laddr;
  logic [2:0]     st_word;
  logic [SB-1:0]  st_be;
  logic [SB*8-1:0] st_data;
  logic           cmt_go, cmt_upd, txn_abort;
  logic           bus_valid, bus_sop, bus_eop, cmt_done;
  logic [BB*8-1:0] bus_data;
  logic [BB-1:0]  bus_be;

  always #10 clk = ~clk;

  txn_commit_bcast u_txn_commit_bcast (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_laddr(st_laddr),
    .st_word(st_word), .st_be(st_be), .st_data(st_data), .st_local(st_local),
    .st_ready(st_ready), .st_ovf(st_ovf), .cmt_go(cmt_go), .cmt_upd(cmt_upd),
    .txn_abort(txn_abort), .bus_valid(bus_valid), .bus_data(bus_data),
    .bus_be(bus_be), .bus_sop(bus_sop), .bus_eop(bus_eop), .cmt_done(cmt_done)
  );

  int n_run = 0;
  int n_fail = 0;

  // bench model of the buffer
  logic [LAW-1:0] m_la [N];
  logic [7:0]     m_d  [N][LB];
  bit [LB-1:0]    m_k  [N];
  int             m_n = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_store(input logic [LAW-1:0] la, input int w,
                             input logic [7:0] be, input logic [63:0] d, input bit loc);
    int e = -1;
    for (int i = 0; i < m_n; i++) if (m_la[i] == la) e = i;
    if (e < 0) begin
      e = m_n; m_n++; m_la[e] = la; m_k[e] = '0;
    end
    if (!loc) begin
      for (int b = 0; b < SB; b++) begin
        if (be[b]) begin
          m_d[e][w*SB+b] = d[b*8 +: 8];
          m_k[e][w*SB+b] = 1'b1;
        end
      end
    end
  endtask

  task automatic do_store(input logic [LAW-1:0] la, input int w, input logic [7:0] be,
                          input logic [63:0] d, input bit loc, output bit rdy, output bit ovf);
    @(negedge clk);
    st_valid = 1'b1; st_laddr = la; st_word = 3'(w); st_be = be;
    st_data = d; st_local = loc;
    #1;
    rdy = st_ready; ovf = st_ovf;
    @(posedge clk);
    #1;
    st_valid = 1'b0;
    if (rdy) model_store(la, w, be, d, loc);
  endtask

  // commit and compare the whole beat stream against the model
  task automatic do_commit(input bit upd, input bit disturb, input string req);
    logic [63:0] e_d [64];
    logic [7:0]  e_b [64];
    bit          e_s [64];
    bit          e_e [64];
    int nb = 0;
    int nl = 0;
    int li = 0;
    int beats = upd ? UB : IB;
    for (int e = 0; e < m_n; e++) if (m_k[e] != '0) nl++;
    for (int e = 0; e < m_n; e++) begin
      if (m_k[e] != '0) begin
        logic [31:0] hdr = {m_la[e], 6'b0};
        for (int bt = 0; bt < beats; bt++) begin
          e_d[nb] = '0; e_b[nb] = '0;
          for (int l = 0; l < BB; l++) begin
            int j = bt*BB + l;
            if (j < HB) begin
              e_d[nb][l*8 +: 8] = hdr[j*8 +: 8]; e_b[nb][l] = 1'b1;
            end else if (upd && j < HB + LB && m_k[e][j-HB]) begin
              e_d[nb][l*8 +: 8] = m_d[e][j-HB]; e_b[nb][l] = 1'b1;
            end
          end
          e_s[nb] = (li == 0) && (bt == 0);
          e_e[nb] = (li == nl - 1) && (bt == beats - 1);
          nb++;
        end
        li++;
      end
    end
    @(negedge clk);
    chk(!bus_valid, "R1", "bus idle before grant", 64'(bus_valid), 0);
    cmt_go = 1'b1; cmt_upd = upd;
    @(negedge clk);
    cmt_go = 1'b0;
    for (int k = 0; k < nb; k++) begin
      if (disturb && k == 1) begin
        st_valid = 1'b1; st_laddr = 26'h3ff; st_word = 0; st_be = 8'hff;
        st_data = 64'hdead; st_local = 1'b0;
      end
      if (disturb && k == 2) txn_abort = 1'b1;
      #1;
      if (disturb && k == 1)
        chk(!st_ready, "R11", "store refused during send", 64'(st_ready), 0);
      chk(bus_valid, "R7", "beat present", 64'(bus_valid), 1);
      chk(bus_data == e_d[k], req, "R5 beat data", bus_data, e_d[k]);
      chk(bus_be == e_b[k], req, "R6 beat strobe", 64'(bus_be), 64'(e_b[k]));
      chk(bus_sop == e_s[k] && bus_eop == e_e[k], "R7", "sop/eop",
          {62'b0, bus_sop, bus_eop}, {62'b0, e_s[k], e_e[k]});
      chk(!cmt_done, "R10", "no done mid packet", 64'(cmt_done), 0);
      @(negedge clk);
      st_valid = 1'b0; txn_abort = 1'b0;
    end
    #1;
    chk(cmt_done && !bus_valid, "R10", "done after last beat",
        {62'b0, cmt_done, bus_valid}, 64'b10);
    chk(st_ready, "R10", "ready in done cycle", 64'(st_ready), 1);
    @(negedge clk);
    chk(!cmt_done && !bus_valid, "R10", "done is one cycle",
        {62'b0, cmt_done, bus_valid}, 0);
    m_n = 0;
  endtask

  // stimulus table: laddr, word, be, local, expect ready, expect overflow
  localparam logic [21:0] VEC [8] = '{
    {8'h10, 3'd0, 8'hff, 1'b0, 1'b1, 1'b0},
    {8'h10, 3'd3, 8'h0f, 1'b0, 1'b1, 1'b0},
    {8'h20, 3'd1, 8'hff, 1'b1, 1'b1, 1'b0},
    {8'h30, 3'd7, 8'hf0, 1'b0, 1'b1, 1'b0},
    {8'h40, 3'd2, 8'h81, 1'b0, 1'b1, 1'b0},
    {8'h50, 3'd0, 8'hff, 1'b0, 1'b0, 1'b1},
    {8'h10, 3'd0, 8'h0f, 1'b0, 1'b1, 1'b0},
    {8'h20, 3'd4, 8'h03, 1'b1, 1'b1, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit r, o;
    rst_n = 1'b0; st_valid = 0; st_laddr = 0; st_word = 0; st_be = 0;
    st_data = 0; st_local = 0; cmt_go = 0; cmt_upd = 0; txn_abort = 0;
    repeat (3) @(negedge clk);
    chk(!bus_valid && bus_data == 0, "R1", "reset bus idle", bus_data, 0);
    chk(!cmt_done, "R10", "reset no done", 64'(cmt_done), 0);
    chk(st_ready && !st_ovf, "R3", "reset ready, no overflow",
        {62'b0, st_ready, st_ovf}, 64'b10);
    rst_n = 1'b1;

    // table walk: R2 merge, R3 overflow, R4 local allocation
    for (int i = 0; i < 8; i++) begin
      logic [21:0] v = VEC[i];
      logic [63:0] d = 64'h0102030405060708 * 64'(i + 1);
      do_store({18'b0, v[21:14]}, int'(v[13:11]), v[10:3], d, v[2], r, o);
      chk(r == v[1], "R3", $sformatf("vec %0d ready", i), 64'(r), 64'(v[1]));
      chk(o == v[0], "R3", $sformatf("vec %0d overflow", i), 64'(o), 64'(v[0]));
    end

    // update packet: lines 0x10, 0x30, 0x40; local line 0x20 skipped (R4, R2)
    do_commit(1'b1, 1'b1, "R4");

    // invalidate packet (R8, R6)
    do_store(26'h1234, 5, 8'h3c, 64'h1111, 0, r, o);
    do_store(26'h0077, 0, 8'h01, 64'h2222, 0, r, o);
    do_store(26'h1234, 6, 8'hff, 64'h3333, 1, r, o);
    do_commit(1'b0, 1'b0, "R8");

    // after done, a full set of new lines fits again (R10)
    for (int i = 0; i < N; i++) do_store(26'(i + 100), i, 8'hff, 64'(i), 0, r, o);
    chk(r, "R10", "buffer empty after commit", 64'(r), 1);
    do_store(26'h999, 0, 8'hff, 64'h5, 0, r, o);
    chk(o, "R3", "overflow on fifth line", 64'(o), 1);
    do_commit(1'b1, 1'b0, "R5");

    // abort before commit discards everything (R9)
    do_store(26'h55, 1, 8'hff, 64'h77, 0, r, o);
    @(negedge clk); txn_abort = 1'b1; #1;
    chk(!st_ready, "R11", "store refused with abort", 64'(st_ready), 0);
    @(negedge clk); txn_abort = 1'b0;
    m_n = 0;
    do_commit(1'b1, 1'b0, "R9");

    // abort together with grant: abort wins (R9)
    do_store(26'h66, 2, 8'hff, 64'h88, 0, r, o);
    @(negedge clk); txn_abort = 1'b1; cmt_go = 1'b1; cmt_upd = 1'b1;
    @(negedge clk); txn_abort = 1'b0; cmt_go = 1'b0;
    chk(!bus_valid && !cmt_done, "R9", "abort beats grant",
        {62'b0, bus_valid, cmt_done}, 0);
    m_n = 0;
    do_commit(1'b1, 1'b0, "R9");

    // only local stores: nothing to send (R4)
    do_store(26'h42, 0, 8'hff, 64'h9, 1, r, o);
    m_n = 0;
    do_commit(1'b1, 1'b0, "R4");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule